// File: doc/BRIEF.md
# Serial Line Transmitter with Idle Preamble and Break Generation

This block serialises characters for an asynchronous serial link. Software-side logic writes a character into a single holding register. When the line is free, the character moves into a shift register and goes out framed with a start bit, 8 or 9 data bits sent least significant bit first, and a stop bit. Parity can optionally be put in place of the last data bit. Timing comes from an external tick at sixteen times the bit rate, and every bit occupies sixteen ticks.

Two special line conditions share the shift register with ordinary characters. An idle preamble is a frame-length stretch of mark (logic 1). Each rising edge of the enable input queues one preamble, so toggling the enable low and then high between two messages inserts exactly one idle frame. A break is a frame-length stretch of space (logic 0). Break frames follow one another without a gap for as long as the break request is held. When the request is released, the break in flight finishes and exactly one mark bit is sent before anything else. A completion flag tells the surrounding logic when the line is fully quiet.

Top module: `sertx_top`

## Requirements
- R1: After reset, and at any time no frame is being shifted, `txd` is 1. Directly after reset, `hold_empty` is 1 and `tx_done` is 1 (with `tx_en` low).
- R2: A data frame is one start bit of 0, then D data bits least significant bit first, then one stop bit of 1. D is 8 when `len9`=0 and 9 when `len9`=1, giving 10 or 11 bits. In 8-bit mode, `wr_data[8]` is ignored.
- R3: With `par_en`=1, the last data position (data bit D-1) carries a parity bit. This bit is the XOR of data bits 0 to D-2, inverted when `par_odd`=1.
- R4: `hold_empty` goes low on the clock after `wr_stb` and rises on the tick where the character moves into the shift register. A character waiting when a frame ends starts on the very next bit slot, with no idle gap.
- R5: Lowering `tx_en` while a frame shifts does not cut it short. While `tx_en` is low, no new frame starts and a written character stays in the holding register.
- R6: Each rising edge of `tx_en` queues one preamble. A preamble is all ones, has the same length as a data frame, and goes out before the next data frame, after any frame in flight.
- R7: A break frame is all zeros, with no start, stop or parity bit. It is 10 bits long when `len9`=0 and 11 bits long when `len9`=1.
- R8: While `brk_req` and `tx_en` are both 1, break frames load back to back into the shift register.
- R9: After `brk_req` is released, the current break finishes and then exactly one mark bit (16 ticks of 1) is sent before any other frame.
- R10: `tx_done` is 1 exactly when no frame is shifting, the holding register is empty, and neither a preamble nor a break is pending. It rises on the tick that ends the last frame.
- R11: Every bit lasts 16 ticks of `tick16`, however irregularly the ticks arrive. Nothing in the transmit state advances on a clock without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; a rising edge queues a preamble |
| brk_req | input | 1 | Hold high to send break frames |
| len9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Parity replaces the last data bit |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| wr_stb | input | 1 | Writes `wr_data` into the holding register |
| wr_data | input | 9 | Character to send |
| tick16 | input | 1 | Baud tick at 16x the bit rate |
| txd | output | 1 | Serial line, 1 when idle |
| hold_empty | output | 1 | Holding register is empty |
| tx_done | output | 1 | Line fully quiet, nothing pending |

## Verification
A frame loaded on tick L shows its bit k from tick L+16k to tick L+16k+15, so the bench counts ticks rather than clocks. Its line decoder samples each bit at tick offset 8 of that bit. A load needs a tick and a free shifter. Because of this, a preamble started by an enable edge at tick E places the following data start bit at exactly E+16N. Data queued behind a frame starting at S begins at S+16N, and data behind a break that ends at tick B begins at B+16. `hold_empty` and `tx_done` are compared at the tick intervals where they must change, and also at the interval just before.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned DMAX = 9;
    localparam int unsigned FMAX = DMAX + 2;
    localparam int unsigned LENW = $clog2(FMAX + 1);

    typedef enum logic [1:0] {
        FK_DATA,
        FK_PRE,
        FK_BRK,
        FK_MARK
    } fkind_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } fmt_t;

    typedef struct packed {
        fkind_e             kind;
        logic [FMAX-1:0]    bits;
        logic [LENW-1:0]    len;
    } frame_t;

    function automatic logic [LENW-1:0] frame_bits(input logic nine);
        return nine ? LENW'(FMAX) : LENW'(FMAX - 1);
    endfunction

    // Builds the line image of a character, bit 0 goes out first.
    function automatic logic [FMAX-1:0] pack_data(input logic [DMAX-1:0] d, input fmt_t f);
        logic [FMAX-1:0] v;
        logic            p;
        int unsigned     nd;
        nd   = f.nine ? DMAX : DMAX - 1;
        v    = '1;
        v[0] = 1'b0;
        p    = f.par_odd;
        for (int i = 0; i < DMAX; i++) begin
            if (i < nd) begin
                if (f.par_en && (i == nd - 1)) begin
                    v[i+1] = p;
                end else begin
                    v[i+1] = d[i];
                    p      = p ^ d[i];
                end
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_stb) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    AST_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> full);                                                   // R4
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_stb) |=> !full);                                     // R4

endmodule

// File: rtl/sertx_sched.sv
module sertx_sched
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              brk_req,
    input  fmt_t              fmt,
    input  logic              hold_full,
    input  logic [DMAX-1:0]   hold_data,
    input  logic              tick,
    input  logic              busy,
    input  logic              frame_end,
    input  fkind_e            cur_kind,
    output logic              load,
    output logic              take,
    output frame_t            nxt,
    output logic              quiet
);

    logic en_q;
    logic pre_pend;
    logic pre_evt;
    logic pre_any;
    logic brk_go;
    logic after_brk;
    logic slot;
    logic have;

    assign pre_evt   = tx_en & ~en_q;
    assign pre_any   = tx_en & (pre_pend | pre_evt);
    assign brk_go    = tx_en & brk_req;
    assign after_brk = frame_end & (cur_kind == FK_BRK);
    assign slot      = tick & (~busy | frame_end);
    assign quiet     = ~pre_any & ~brk_go;

    // Priority: break, owed mark, preamble, data.
    always_comb begin
        nxt.kind = FK_DATA;
        nxt.bits = '1;
        nxt.len  = frame_bits(fmt.nine);
        have     = 1'b1;
        if (brk_go) begin
            nxt.kind = FK_BRK;
            nxt.bits = '0;
        end else if (after_brk) begin
            nxt.kind = FK_MARK;
            nxt.len  = LENW'(1);
        end else if (pre_any) begin
            nxt.kind = FK_PRE;
        end else if (tx_en && hold_full) begin
            nxt.bits = pack_data(hold_data, fmt);
        end else begin
            have = 1'b0;
        end
    end

    assign load = slot & have;
    assign take = load & (nxt.kind == FK_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            pre_pend <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (!tx_en) begin
                pre_pend <= 1'b0;
            end else if (load && (nxt.kind == FK_PRE)) begin
                pre_pend <= 1'b0;
            end else if (pre_evt) begin
                pre_pend <= 1'b1;
            end
        end
    end

    AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        load |-> tick);                                                   // R11

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    load,
    input  frame_t  nxt,
    output logic    busy,
    output logic    txd,
    output logic    frame_end,
    output fkind_e  cur_kind
);

    localparam int unsigned SUBW = (OVS > 1) ? $clog2(OVS) : 1;

    logic [FMAX-1:0] shreg;
    logic [LENW-1:0] left;
    logic [SUBW-1:0] sub;
    logic            bit_end;

    assign bit_end   = tick & busy & (sub == SUBW'(OVS - 1));
    assign frame_end = bit_end & (left == LENW'(1));
    assign txd       = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            shreg    <= '1;
            left     <= '0;
            sub      <= '0;
            cur_kind <= FK_DATA;
        end else if (load) begin
            busy     <= 1'b1;
            shreg    <= nxt.bits;
            left     <= nxt.len;
            sub      <= '0;
            cur_kind <= nxt.kind;
        end else if (frame_end) begin
            busy  <= 1'b0;
            shreg <= '1;
        end else if (bit_end) begin
            shreg <= {1'b1, shreg[FMAX-1:1]};
            left  <= left - LENW'(1);
            sub   <= '0;
        end else if (tick && busy) begin
            sub <= sub + SUBW'(1);
        end
    end

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_end) |=> busy);                                   // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(txd));                               // R11

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_en,
    input  logic            brk_req,
    input  logic            len9,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            wr_stb,
    input  logic [DMAX-1:0] wr_data,
    input  logic            tick16,
    output logic            txd,
    output logic            hold_empty,
    output logic            tx_done
);

    fmt_t            fmt;
    frame_t          nxt;
    fkind_e          cur_kind;
    logic            hold_full;
    logic [DMAX-1:0] hold_data;
    logic            take;
    logic            load;
    logic            busy;
    logic            frame_end;
    logic            quiet;

    assign fmt = '{nine: len9, par_en: par_en, par_odd: par_odd};

    sertx_hold #(.W(DMAX)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_sched u_sched (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .fmt       (fmt),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .tick      (tick16),
        .busy      (busy),
        .frame_end (frame_end),
        .cur_kind  (cur_kind),
        .load      (load),
        .take      (take),
        .nxt       (nxt),
        .quiet     (quiet)
    );

    sertx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .load      (load),
        .nxt       (nxt),
        .busy      (busy),
        .txd       (txd),
        .frame_end (frame_end),
        .cur_kind  (cur_kind)
    );

    assign hold_empty = ~hold_full;
    assign tx_done    = ~busy & ~hold_full & quiet;

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> txd);                                                 // R1
    AST_PRE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == FK_PRE) |-> txd);                            // R6
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == FK_BRK) |-> !txd);                           // R7
    AST_BRK_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (frame_end && cur_kind == FK_BRK && tx_en && brk_req) |=> (busy && !txd)); // R8
    AST_MARK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (frame_end && cur_kind == FK_BRK && !(tx_en && brk_req)) |=> (busy && txd)); // R9

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       len9 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tick16 = 1'b1;
    logic       txd;
    logic       hold_empty;
    logic       tx_done;

    always #2 clk = ~clk;

    sertx_top i_sertx_top (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .brk_req    (brk_req),
        .len9       (len9),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .tick16     (tick16),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_done    (tx_done)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  rnd_tick = 1'b0;
    bit  finished = 1'b0;

    // tick-level line decoder
    int          tk = 0;
    int          st = 0;
    int          s_tk = 0;
    int          nb = 0;
    logic [10:0] acc = '0;
    bit          he_s, phe_s;
    bit          prev_he = 1'b1;
    logic [10:0] fr_bits [128];
    int          fr_start [128];
    bit          fr_he [128];
    bit          fr_phe [128];
    int          nfr = 0;
    int          done_tk = -1;
    bit          prev_done = 1'b0;

    function automatic int rxn();
        return len9 ? 11 : 10;
    endfunction

    function automatic logic [10:0] nmask();
        return len9 ? 11'h7ff : 11'h3ff;
    endfunction

    function automatic logic [10:0] exp_frame(logic [8:0] d, bit nine, bit pe, bit po);
        logic [10:0] v;
        int          nd;
        bit          par;
        nd   = nine ? 9 : 8;
        v    = '0;
        for (int i = 0; i < nd; i++) v[i+1] = d[i];
        if (pe) begin
            par = po;
            for (int i = 0; i < nd - 1; i++) par = par ^ d[i];
            v[nd] = par;
        end
        v[nd+1] = 1'b1;
        return v;
    endfunction

    always @(posedge clk) begin
        #1;
        if (!rst && tick16) begin
            tk++;
            if (st == 1 && tk - s_tk == 16 * rxn()) st = 0;
            if (st == 0) begin
                if (!txd) begin
                    st = 1; s_tk = tk; nb = 0; acc = '0;
                    he_s = hold_empty; phe_s = prev_he;
                end
            end
            if (st == 1 && nb < rxn() && tk - s_tk == 8 + 16 * nb) begin
                acc[nb] = txd;
                nb++;
                if (nb == rxn() && nfr < 128) begin
                    fr_bits[nfr] = acc; fr_start[nfr] = s_tk;
                    fr_he[nfr] = he_s; fr_phe[nfr] = phe_s;
                    nfr++;
                end
            end
            prev_he = hold_empty;
        end
        if (tx_done && !prev_done) done_tk = tk;
        prev_done = tx_done;
    end

    initial forever begin
        @(negedge clk);
        tick16 = rnd_tick ? 1'($urandom % 2) : 1'b1;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wait_frames(int n);
        int t = 0;
        while (nfr < n && t < 20000) begin @(negedge clk); t++; end
        chk(nfr >= n, "R2 frame arrival", nfr, n);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!tx_done && t < 20000) begin @(negedge clk); t++; end
        chk(tx_done, "R10 line quiet", tx_done, 1);
    endtask

    task automatic write_byte(logic [8:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int e, b0, base, t, gap;
        logic [8:0]  d, d2;
        logic [10:0] expq [5];
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty reset", hold_empty, 1);
        chk(tx_done == 1'b1, "R1 tx_done reset", tx_done, 1);

        // R6 enable edge queues preamble, R2 format, R4 hold timing
        @(negedge clk);
        tx_en = 1'b1; wr_stb = 1'b1; wr_data = 9'h0a5; e = tk + 1;
        @(negedge clk); wr_stb = 1'b0;
        chk(tx_done == 1'b0, "R10 busy not done", tx_done, 0);
        chk(hold_empty == 1'b0, "R4 write fills hold", hold_empty, 0);
        wait_frames(1);
        chk(fr_start[0] == e + 160, "R6 preamble before data", fr_start[0], e + 160);
        chk(fr_bits[0][9:0] == exp_frame(9'h0a5, 0, 0, 0)[9:0], "R2 8-bit frame", fr_bits[0], exp_frame(9'h0a5, 0, 0, 0));
        chk(fr_he[0] == 1'b1 && fr_phe[0] == 1'b0, "R4 empty rises at load", {fr_phe[0], fr_he[0]}, 2'b01);
        wait_done();
        chk(done_tk == fr_start[0] + 160, "R10 done at frame end", done_tk, fr_start[0] + 160);

        // R4 back to back, R3 even parity, 9-bit
        @(negedge clk); len9 = 1'b1; par_en = 1'b1; par_odd = 1'b0;
        d = 9'h13c; d2 = 9'h0e7;
        write_byte(d);
        while (!hold_empty) @(negedge clk);
        write_byte(d2);
        wait_frames(3);
        chk(fr_bits[1] == exp_frame(d, 1, 1, 0), "R3 even parity 9-bit", fr_bits[1], exp_frame(d, 1, 1, 0));
        chk(fr_bits[2] == exp_frame(d2, 1, 1, 0), "R3 even parity 9-bit", fr_bits[2], exp_frame(d2, 1, 1, 0));
        chk(fr_start[2] == fr_start[1] + 176, "R4 back-to-back", fr_start[2], fr_start[1] + 176);
        wait_done();

        // R5 enable drop mid-frame, R3 odd parity
        @(negedge clk); len9 = 1'b0; par_en = 1'b1; par_odd = 1'b1;
        d = 9'h05b;
        write_byte(d);
        t = 0;
        while (!(st == 1 && tk - s_tk >= 20) && t < 2000) begin @(negedge clk); t++; end
        tx_en = 1'b0;
        wait_frames(4);
        chk((fr_bits[3] & nmask()) == exp_frame(d, 0, 1, 1), "R5 frame completes", fr_bits[3], exp_frame(d, 0, 1, 1));
        write_byte(9'h1c3);
        repeat (400) @(negedge clk);
        chk(nfr == 4, "R5 no frame while disabled", nfr, 4);
        chk(hold_empty == 1'b0, "R5 hold kept", hold_empty, 0);
        chk(txd == 1'b1, "R1 idle while disabled", txd, 1);
        chk(tx_done == 1'b0, "R10 pending data not done", tx_done, 0);
        @(negedge clk); tx_en = 1'b1; e = tk + 1;
        wait_frames(5);
        chk(fr_start[4] == e + 160, "R6 preamble on re-enable", fr_start[4], e + 160);
        chk((fr_bits[4] & nmask()) == exp_frame(9'h1c3, 0, 1, 1), "R2 bit 8 ignored", fr_bits[4], exp_frame(9'h1c3, 0, 1, 1));
        wait_done();

        // R6 toggle while shifting
        @(negedge clk); par_en = 1'b0;
        write_byte(9'h03c);
        while (!hold_empty) @(negedge clk);
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk); tx_en = 1'b1; wr_stb = 1'b1; wr_data = 9'h0c3;
        @(negedge clk); wr_stb = 1'b0;
        wait_frames(7);
        chk(fr_start[6] == fr_start[5] + 320, "R6 toggle inserts preamble", fr_start[6], fr_start[5] + 320);
        chk((fr_bits[6] & nmask()) == exp_frame(9'h0c3, 0, 0, 0), "R2 frame after preamble", fr_bits[6], exp_frame(9'h0c3, 0, 0, 0));
        wait_done();

        // R7 R8 R9 break in 9-bit mode
        @(negedge clk); len9 = 1'b1;
        @(negedge clk); brk_req = 1'b1; b0 = tk + 1;
        @(negedge clk);
        chk(tx_done == 1'b0, "R10 break pending", tx_done, 0);
        while (tk < b0 + 352 + 50) @(negedge clk);
        brk_req = 1'b0; wr_stb = 1'b1; wr_data = 9'h1a6;
        @(negedge clk); wr_stb = 1'b0;
        wait_frames(11);
        for (int k = 0; k < 3; k++) begin
            chk(fr_bits[7+k] == 11'h000, "R7 break all zero", fr_bits[7+k], 0);
            chk(fr_start[7+k] == b0 + 176 * k, "R8 breaks back to back", fr_start[7+k], b0 + 176 * k);
        end
        chk(fr_start[10] == b0 + 528 + 16, "R9 one mark bit", fr_start[10], b0 + 544);
        chk(fr_bits[10] == exp_frame(9'h1a6, 1, 0, 0), "R2 data after break", fr_bits[10], exp_frame(9'h1a6, 1, 0, 0));
        wait_done();

        // R7 short break, 8-bit length
        @(negedge clk); len9 = 1'b0;
        @(negedge clk); brk_req = 1'b1;
        repeat (20) @(negedge clk);
        brk_req = 1'b0;
        repeat (300) @(negedge clk);
        chk(nfr == 12, "R7 single break", nfr, 12);
        chk((fr_bits[11] & nmask()) == 11'h000, "R7 10-bit break", fr_bits[11], 0);
        chk(tx_done == 1'b1 && txd == 1'b1, "R9 line back to mark", {tx_done, txd}, 2'b11);

        // R11 random ticks, random formats
        rnd_tick = 1'b1;
        for (int c = 0; c < 6; c++) begin
            wait_done();
            @(negedge clk);
            len9 = 1'($urandom % 2); par_en = 1'($urandom % 2); par_odd = 1'($urandom % 2);
            base = nfr;
            for (int k = 0; k < 5; k++) begin
                d = 9'($urandom);
                expq[k] = exp_frame(d, len9, par_en, par_odd);
                t = 0;
                while (!hold_empty && t < 20000) begin @(negedge clk); t++; end
                gap = $urandom % 40;
                repeat (gap) @(negedge clk);
                write_byte(d);
            end
            wait_frames(base + 5);
            for (int k = 0; k < 5; k++)
                chk((fr_bits[base+k] & nmask()) == expq[k], "R11 random frame", fr_bits[base+k], expq[k]);
        end
        wait_done();

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule